// File: doc/BRIEF.md
# AES3 Subframe Sequencer with Channel-Status, User and Validity Capture

This block paces AES3 transmission for a downstream biphase-mark encoder. It runs on the master oversampling clock and divides it into subframes of `SUB_CLKS` clocks. It marks the start of every subframe with a one-cycle strobe, and it picks the preamble type for each subframe. A channel-status block is `FRAMES` frames long, and its first A subframe carries the Z preamble. Alongside the strobe it produces a virtual word clock. It latches the channel-status, user and validity pins at the edge of that clock, which opens each subframe.

The block-sync line works in one of two directions. As an input, a high pulse that lasts more than three master clocks restarts the frame and the block. As an output, it is high for the whole of the first frame of each block. In that mode, subframe A is also locked to the leading edge of an external word clock, and a polarity select chooses which level of that clock marks A. Mono mode doubles the virtual word clock, so the A and B subframes take their bits from consecutive samples.

Top module: `aes3_subframe_seq`

## Requirements
- R1: While reset is asserted, `sf_stb` is 1, `pre` is Z (2), `vwclk` is 1 and `c_out`, `u_out`, `v_out` are 0. The first subframe after reset is the A subframe of frame 0.
- R2: With block sync set as an input, subframes follow each other every `SUB_CLKS` clocks, and `sf_stb` is high only in the first cycle of each one.
- R3: `pre` encodes X as 0, Y as 1 and Z as 2. The A subframe of frame 0 is Z, every B subframe is Y, and every other A subframe is X. When nothing restarts the block, Z recurs every 2·`FRAMES`·`SUB_CLKS` clocks.
- R4: With block sync as an input, the fourth consecutive clock that samples `sync_in` high starts a new frame and block. The next cycle shows `sf_stb`=1 and `pre`=Z. This restart takes priority over a subframe boundary that falls in the same cycle. A pulse of 3 clocks or fewer changes nothing, and a line held high restarts only once.
- R5: `sync_oe` equals `sync_dir_out`. With block sync as an output, `sync_out` is high through both subframes of frame 0 and low otherwise, and `sync_in` is ignored. With block sync as an input, `sync_out` is 0.
- R6: With block sync as an output, the A level of `wclk_in` is high when `wclk_pol`=0 and low when `wclk_pol`=1. In stereo, the clock after `wclk_in` enters the A level shows `sf_stb`=1 with an A preamble (X or Z). The B subframe starts `SUB_CLKS` clocks later and lasts until the next leading edge.
- R7: In stereo, `vwclk` is high during A and low during B. In mono, `vwclk` is high for the first `SUB_CLKS`/2 clocks of every subframe and low for the rest.
- R8: The values on `c_in`, `u_in` and `v_in` during a strobe cycle appear on `c_out`, `u_out` and `v_out` in the following cycle. They stay there until the next strobe, whatever the pins do in between. In mono mode, the two subframes of a frame carry consecutive samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master oversampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mono | input | 1 | 1 selects mono mode (word clock at twice the frame rate) |
| sync_dir_out | input | 1 | 1: block sync is an output and aligns to `wclk_in`; 0: block sync is an input |
| wclk_pol | input | 1 | Selects which `wclk_in` level marks subframe A |
| wclk_in | input | 1 | External word clock used for alignment in output mode |
| sync_in | input | 1 | Block-sync line as seen when driven from outside |
| c_in | input | 1 | Channel-status bit pin |
| u_in | input | 1 | User bit pin |
| v_in | input | 1 | Validity bit pin |
| sync_out | output | 1 | Block-sync value driven in output mode |
| sync_oe | output | 1 | Output enable for the block-sync line |
| vwclk | output | 1 | Virtual word clock |
| sf_stb | output | 1 | One-cycle strobe at the start of each subframe |
| pre | output | 2 | Preamble code: 0 X, 1 Y, 2 Z |
| c_out | output | 1 | Captured channel-status bit for the current subframe |
| u_out | output | 1 | Captured user bit for the current subframe |
| v_out | output | 1 | Captured validity bit for the current subframe |

## Verification
A qualified block-sync restart can fire on the very clock where the subframe counter wraps from the end of a B subframe into the next frame. To provoke this, the bench raises `sync_in` four clocks before the last clock of a B subframe in mid-block, so the fourth high sample and the natural boundary fall on the same edge. The restart is judged to have won if the next strobe carries Z rather than X and the following Z arrives exactly one full block of clocks later. A table of pulse widths, some at and some below the threshold, covers the qualifier on its own.

// File: rtl/aes3_subframe_seq.sv
module aes3_subframe_seq #(
  parameter int SUB_CLKS = 64,
  parameter int FRAMES   = 192,
  parameter int SYNC_MIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mono,
  input  logic       sync_dir_out,
  input  logic       wclk_pol,
  input  logic       wclk_in,
  input  logic       sync_in,
  input  logic       c_in,
  input  logic       u_in,
  input  logic       v_in,
  output logic       sync_out,
  output logic       sync_oe,
  output logic       vwclk,
  output logic       sf_stb,
  output logic [1:0] pre,
  output logic       c_out,
  output logic       u_out,
  output logic       v_out
);
  localparam int CW = $clog2(SUB_CLKS);
  localparam int FW = $clog2(FRAMES);
  localparam int SW = $clog2(SYNC_MIN + 1);
  localparam logic [1:0] PRE_X = 2'd0;
  localparam logic [1:0] PRE_Y = 2'd1;
  localparam logic [1:0] PRE_Z = 2'd2;

  logic [CW-1:0] sub_cnt;
  logic [FW-1:0] frame;
  logic [SW-1:0] hi_cnt;
  logic          sub_b, a_q;

  wire a_lvl      = wclk_in ^ wclk_pol;
  wire lead       = sync_dir_out & a_lvl & ~a_q;
  wire restart    = ~sync_dir_out & sync_in & (hi_cnt == SW'(SYNC_MIN - 1));
  wire tick       = sub_cnt == CW'(SUB_CLKS - 1);
  wire step       = sync_dir_out ? (lead | (tick & ~mono & ~sub_b)) : tick;
  wire next_b     = (lead & ~mono) ? 1'b0 : ~sub_b;
  wire frame_last = frame == FW'(FRAMES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_cnt <= '0;
      sub_b   <= 1'b0;
      frame   <= '0;
      hi_cnt  <= '0;
      a_q     <= 1'b0;
      {c_out, u_out, v_out} <= 3'b000;
    end else begin
      a_q <= a_lvl;
      if (!sync_in)                     hi_cnt <= '0;
      else if (hi_cnt != SW'(SYNC_MIN)) hi_cnt <= hi_cnt + 1'b1;

      if (restart) begin
        sub_cnt <= '0;
        sub_b   <= 1'b0;
        frame   <= '0;
      end else if (step) begin
        sub_cnt <= '0;
        sub_b   <= next_b;
        if (!next_b) frame <= frame_last ? '0 : frame + 1'b1;
      end else if (!tick) begin
        sub_cnt <= sub_cnt + 1'b1;
      end

      if (sf_stb) {c_out, u_out, v_out} <= {c_in, u_in, v_in};
    end
  end

  assign sf_stb   = sub_cnt == '0;
  assign pre      = sub_b ? PRE_Y : ((frame == '0) ? PRE_Z : PRE_X);
  assign vwclk    = mono ? (sub_cnt < CW'(SUB_CLKS / 2)) : ~sub_b;
  assign sync_oe  = sync_dir_out;
  assign sync_out = sync_dir_out & (frame == '0);
endmodule

module aes3_subframe_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mono,
  input logic       sync_dir_out,
  input logic       wclk_pol,
  input logic       wclk_in,
  input logic       sync_in,
  input logic       c_in,
  input logic       u_in,
  input logic       v_in,
  input logic       sync_out,
  input logic       sync_oe,
  input logic       vwclk,
  input logic       sf_stb,
  input logic [1:0] pre,
  input logic       c_out,
  input logic       u_out,
  input logic       v_out
);
  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;
  end

  assert_sync_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd5 && !sync_oe && sync_in && $past(sync_in) && $past(sync_in, 2)
     && $past(sync_in, 3) && !$past(sync_in, 4)) |=> (sf_stb && pre == 2'd2));

  assert_cuv_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sf_stb |=> ({c_out, u_out, v_out} == $past({c_in, u_in, v_in})));

  assert_cuv_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_stb |=> $stable({c_out, u_out, v_out}));

  assert_sync_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_oe |-> !sync_out);

  assert_sync_frame0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> pre != 2'd0);

  assert_vwclk_stereo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mono |-> vwclk == (pre != 2'd1));

  assert_pre_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pre != 2'd3);

  assert_wclk_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd1 && sync_oe && !mono && $stable(wclk_pol)
     && (wclk_in ^ wclk_pol) && !($past(wclk_in) ^ wclk_pol)) |=> (sf_stb && pre != 2'd1));
endmodule

bind aes3_subframe_seq aes3_subframe_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .mono(mono), .sync_dir_out(sync_dir_out),
  .wclk_pol(wclk_pol), .wclk_in(wclk_in), .sync_in(sync_in),
  .c_in(c_in), .u_in(u_in), .v_in(v_in), .sync_out(sync_out), .sync_oe(sync_oe),
  .vwclk(vwclk), .sf_stb(sf_stb), .pre(pre), .c_out(c_out), .u_out(u_out), .v_out(v_out)
);

// File: tb/test_aes3_subframe_seq.sv
module test_aes3_subframe_seq;
  localparam int SUB    = 8;
  localparam int FRAMES = 192;
  localparam int BLOCK_CLKS = 2 * FRAMES * SUB;
  localparam int PULSE_TBL [6][2] = '{'{1, 0}, '{3, 0}, '{4, 2}, '{2, 0}, '{5, 2}, '{7, 2}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mono = 1'b0, sync_dir_out = 1'b0, wclk_pol = 1'b0, wclk_in = 1'b0, sync_in = 1'b0;
  logic c_in = 1'b0, u_in = 1'b0, v_in = 1'b0;
  logic sync_out, sync_oe, vwclk, sf_stb, c_out, u_out, v_out;
  logic [1:0] pre;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  aes3_subframe_seq #(.SUB_CLKS(SUB), .FRAMES(FRAMES), .SYNC_MIN(4)) i_aes3_subframe_seq (
    .clk(clk), .rst_n(rst_n), .mono(mono), .sync_dir_out(sync_dir_out),
    .wclk_pol(wclk_pol), .wclk_in(wclk_in), .sync_in(sync_in),
    .c_in(c_in), .u_in(u_in), .v_in(v_in), .sync_out(sync_out), .sync_oe(sync_oe),
    .vwclk(vwclk), .sf_stb(sf_stb), .pre(pre), .c_out(c_out), .u_out(u_out), .v_out(v_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] pat(input int k);
    return 3'((k * 5 + 3) % 8);
  endfunction

  function automatic int exp_pre(input int k);
    if (k % 2 == 1) return 1;
    return (((k / 2) % FRAMES) == 0) ? 2 : 0;
  endfunction

  task automatic wait_pre(input int code);
    for (int i = 0; i < 4000; i++) begin
      if (sf_stb && pre == 2'(code)) return;
      @(negedge clk);
    end
    chk("align", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all R): actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 strobe in reset", int'(sf_stb), 1);
    chk("R1 preamble in reset", int'(pre), 2);
    chk("R1 vwclk in reset", int'(vwclk), 1);
    chk("R1 cuv in reset", int'({c_out, u_out, v_out}), 0);
    rst_n = 1'b1;

    // R2 R3 R7 R8: two full blocks, stereo, block sync as input
    for (int k = 0; k < 2 * 2 * FRAMES; k++) begin
      chk("R2 strobe at subframe start", int'(sf_stb), 1);
      chk("R3 preamble", int'(pre), exp_pre(k));
      chk("R7 stereo vwclk", int'(vwclk), (k % 2 == 0) ? 1 : 0);
      {c_in, u_in, v_in} = pat(k);
      @(negedge clk);
      chk("R8 cuv captured", int'({c_out, u_out, v_out}), int'(pat(k)));
      chk("R2 strobe one cycle", int'(sf_stb), 0);
      {c_in, u_in, v_in} = ~pat(k);
      repeat (SUB - 2) @(negedge clk);
      chk("R8 cuv held against pin change", int'({c_out, u_out, v_out}), int'(pat(k)));
      chk("R2 no strobe mid subframe", int'(sf_stb), 0);
      @(negedge clk);
    end
    chk("R3 Z after two blocks", int'(pre), 2);

    // R7 R8: mono mode
    mono = 1'b1;
    for (int j = 0; j < 4; j++) begin
      chk("R7 mono strobe", int'(sf_stb), 1);
      chk("R7 mono vwclk at start", int'(vwclk), 1);
      {c_in, u_in, v_in} = pat(100 + j);
      repeat (SUB / 2 - 1) @(negedge clk);
      chk("R7 mono vwclk first half", int'(vwclk), 1);
      @(negedge clk);
      chk("R7 mono vwclk second half", int'(vwclk), 0);
      chk("R8 mono consecutive sample", int'({c_out, u_out, v_out}), int'(pat(100 + j)));
      repeat (SUB / 2 - 1) @(negedge clk);
      chk("R7 mono vwclk end", int'(vwclk), 0);
      @(negedge clk);
    end
    mono = 1'b0;

    // R4: pulse-width table
    foreach (PULSE_TBL[r]) begin
      wait_pre(0);
      sync_in = 1'b1;
      repeat (PULSE_TBL[r][0]) @(negedge clk);
      sync_in = 1'b0;
      chk($sformatf("R4 pulse width %0d", PULSE_TBL[r][0]), int'(pre), PULSE_TBL[r][1]);
      if (PULSE_TBL[r][0] == 4) chk("R4 restart strobe", int'(sf_stb), 1);
      @(negedge clk);
    end

    // R4 R3: restart coinciding with end of a B subframe
    wait_pre(1);
    repeat (SUB - 4) @(negedge clk);
    sync_in = 1'b1;
    repeat (4) @(negedge clk);
    sync_in = 1'b0;
    chk("R4 coincident restart strobe", int'(sf_stb), 1);
    chk("R4 coincident restart preamble", int'(pre), 2);
    begin
      int n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!(sf_stb && pre == 2'd2) && n < 5000);
      chk("R3 Z spacing after restart", n, BLOCK_CLKS);
    end

    // R5 R6: block sync as output, word clock alignment
    sync_dir_out = 1'b1;
    chk("R5 output enable", int'(sync_oe), 1);
    begin
      int zc = 0;
      for (int p = 0; p < FRAMES; p++) begin
        int isz;
        wclk_in = 1'b1;
        @(negedge clk);
        chk("R6 A strobe after leading edge", int'(sf_stb), 1);
        chk("R6 A preamble", int'(pre != 2'd1), 1);
        isz = (pre == 2'd2) ? 1 : 0;
        zc += isz;
        chk("R5 sync_out in A", int'(sync_out), isz);
        repeat (SUB) @(negedge clk);
        chk("R6 B strobe", int'(sf_stb), 1);
        chk("R6 B preamble", int'(pre), 1);
        chk("R5 sync_out in B", int'(sync_out), isz);
        @(negedge clk);
        wclk_in = 1'b0;
        if (p == 5) begin
          sync_in = 1'b1;
          repeat (6) @(negedge clk);
          sync_in = 1'b0;
          chk("R5 sync_in ignored in output mode", int'(pre), 1);
          chk("R5 no strobe from sync_in", int'(sf_stb), 0);
          repeat (4) @(negedge clk);
        end else begin
          repeat (10) @(negedge clk);
        end
      end
      chk("R5 one Z frame per block", zc, 1);
    end

    // R6: inverted polarity, falling edge marks A
    wclk_pol = 1'b1;
    wclk_in = 1'b1;
    for (int p = 0; p < 3; p++) begin
      repeat (10) @(negedge clk);
      chk("R6 no strobe before falling edge", int'(sf_stb), 0);
      wclk_in = 1'b0;
      @(negedge clk);
      chk("R6 inverted polarity A strobe", int'(sf_stb), 1);
      chk("R6 inverted polarity A preamble", int'(pre != 2'd1), 1);
      repeat (9) @(negedge clk);
      wclk_in = 1'b1;
    end

    sync_dir_out = 1'b0;
    @(negedge clk);
    chk("R5 sync_out low in input mode", int'(sync_out), 0);
    chk("R5 output enable off", int'(sync_oe), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule